// File: doc/BRIEF.md
# PPS-Gated Ping-Pong Cycle Counter

This block measures how many cycles of a local oscillator fit between consecutive rising edges of a one-pulse-per-second reference. The block runs on the oscillator clock itself. A basic synchroniser brings the reference in, and each synchronised rising edge flips a gate flip-flop. The result is a square wave at half the reference rate, made of whole seconds. The length of each gate phase never depends on how long the reference pulse stays high.

There are two counters, and they take turns. Counter A is enabled while the gate is high and counter B while it is low, so a whole second of cycles is always being counted. Gating uses a synchronous count enable, not a gated clock. When the gate flips, the counter that has just stopped is copied into a result register, tagged with its source, and announced with a one-cycle ready strobe. On the following cycle that counter is cleared, so it starts its next window at zero.

The counters saturate rather than wrap, and a saturated count carries a sticky overflow flag. The first result after reset comes from a window that did not start at a reference edge, and it is marked partial.

Top module: `pps_pingpong_counter`

## Requirements
- R1: The gate resets low and inverts once for each synchronised rising edge of `pps_in`. Counter A counts only while the gate is high and counter B only while it is low.
- R2: A non-partial result's `res_count` equals the number of clock cycles between the two `pps_in` rising edges that bound its window, when that number fits the counter.
- R3: `res_src` is 0 for counter A and 1 for counter B. Successive results alternate in source, and the first result after reset comes from B.
- R4: `res_ready` is high for exactly one cycle per gate transition. `res_count` changes only in a cycle where `res_ready` is high.
- R5: A window longer than 2^CNT_W-1 cycles yields `res_count` equal to 2^CNT_W-1 with `res_ovf`=1. Shorter windows yield `res_ovf`=0.
- R6: A counter is cleared after its result is taken, so its next window starts from zero and its overflow flag is cleared: a saturated result never affects that counter's next result.
- R7: The first result after reset has `res_partial`=1. Every later result has `res_partial`=0.
- R8: While reset is held, `res_ready`, `res_count`, `res_src`, `res_ovf` and `res_partial` are all 0.
- R9: The high time of `pps_in`, anywhere from one cycle to one cycle less than its period, has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the counted clock and the block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pps_in | input | 1 | Asynchronous pulse-per-second reference |
| res_count | output | CNT_W | Completed window count, saturating |
| res_src | output | 1 | Source of the result: 0 = counter A, 1 = counter B |
| res_ovf | output | 1 | Result saturated |
| res_partial | output | 1 | Result is from the first, incomplete window after reset |
| res_ready | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that consecutive `pps_in` rising edges are at least six clock cycles apart. This leaves time for the latch and the clear to finish before the cleared counter is enabled again. They also assume that each high and low level of `pps_in` lasts at least one full clock cycle. The stimulus keeps to these limits. Every period is drawn from 6 cycles upward, and every high time lies between one cycle and the period minus one. Pulses are driven on falling clock edges, so the synchroniser always sees clean levels.

// File: rtl/ppc_pkg.sv
// Package: shared types and helpers for the PPS ping-pong counter.
// Assumes nothing beyond IEEE 1800-2017 package support.
package ppc_pkg;

    // Identifies which of the two counters a result came from.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    // Number of alternating counters; the gate scheme relies on two.
    localparam int unsigned NUM_CNT = 2;

endpackage

// File: rtl/ppc_sync.sv
// Module: ppc_sync
// Brings an asynchronous level into the clk domain through a chain of
// flops and emits a one-cycle pulse on each rising transition.
// Assumes each input level lasts at least one clock period.
module ppc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the input through the synchroniser plus one edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_in};
        end
    end

    // Rising edge: the synchronised level is high and the older one is low.
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/ppc_gate.sv
// Module: ppc_gate
// Divides the synchronised PPS edges by two to form the gate. It flags
// the cycle after each gate flip, together with the counter that has
// just stopped counting. Assumes rising edges are at least two cycles apart.
module ppc_gate
    import ppc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pps_rise,
    output logic gate,
    output logic win_end,
    output src_e ended_src
);
    logic gate_q;
    logic gate_d;

    // Toggle the gate on each edge; keep a delayed copy for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            gate_d <= 1'b0;
        end else begin
            gate_d <= gate_q;
            if (pps_rise) begin
                gate_q <= ~gate_q;
            end
        end
    end

    assign gate      = gate_q;
    assign win_end   = gate_q ^ gate_d;
    // Before the flip a high gate meant A was counting, a low gate meant B.
    assign ended_src = gate_d ? SRC_A : SRC_B;

endmodule

// File: rtl/ppc_counter.sv
// Module: ppc_counter
// Counts enabled clock cycles and saturates at all-ones. A sticky
// overflow flag is set when an increment is refused. A clear resets both
// and takes priority over the enable.
module ppc_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Saturating increment with a sticky overflow; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (en) begin
            if (count == CNT_MAX) begin
                ovf <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pps_pingpong_counter.sv
// Module: pps_pingpong_counter (top)
// Measures oscillator cycles per PPS second with two counters that take
// turns. The gate from ppc_gate enables A while high and B while low. At
// each gate flip the stopped counter is latched and strobed out, and it is
// cleared one cycle later. Assumes PPS edges are at least six cycles apart.
module pps_pingpong_counter
    import ppc_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_in,
    output logic [CNT_W-1:0] res_count,
    output logic             res_src,
    output logic             res_ovf,
    output logic             res_partial,
    output logic             res_ready
);
    logic             pps_rise;
    logic             gate;
    logic             win_end;
    src_e             ended_src;
    logic             primed_q;
    logic [CNT_W-1:0] cnt_q [NUM_CNT];
    logic             ovf_q [NUM_CNT];
    logic             clr   [NUM_CNT];
    logic             en    [NUM_CNT];

    ppc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pps_in),
        .rise     (pps_rise)
    );

    ppc_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps_rise  (pps_rise),
        .gate      (gate),
        .win_end   (win_end),
        .ended_src (ended_src)
    );

    // One counter per gate phase: index 0 counts on high, index 1 on low.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign en[i]  = (i == 0) ? gate : ~gate;
        assign clr[i] = res_ready && (res_src == i[0]);

        ppc_counter #(.CNT_W(CNT_W)) u_counter (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en[i]),
            .clr   (clr[i]),
            .count (cnt_q[i]),
            .ovf   (ovf_q[i])
        );
    end

    // Latch the stopped counter, tag it, and raise the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_count   <= '0;
            res_src     <= 1'b0;
            res_ovf     <= 1'b0;
            res_partial <= 1'b0;
            res_ready   <= 1'b0;
            primed_q    <= 1'b0;
        end else begin
            res_ready <= win_end;
            if (win_end) begin
                res_count   <= cnt_q[ended_src];
                res_ovf     <= ovf_q[ended_src];
                res_src     <= ended_src;
                res_partial <= ~primed_q;
                primed_q    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pps_pingpong_counter_chk.sv
// Module: pps_pingpong_counter_chk
// Assertion checker bound into pps_pingpong_counter. Assumes PPS rising
// edges are at least six clock cycles apart.
module pps_pingpong_counter_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pps_rise,
    input logic             gate,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [CNT_W-1:0] res_count,
    input logic             res_src,
    input logic             res_ovf,
    input logic             res_partial,
    input logic             res_ready
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic have_prev;
    logic last_src;

    // Remember the source of the previous result for the alternation check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            last_src  <= 1'b0;
        end else if (res_ready) begin
            have_prev <= 1'b1;
            last_src  <= res_src;
        end
    end

    a_r1_gate_flips_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pps_rise |=> (gate != $past(gate)));
    a_r1_gate_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate) |-> $past(pps_rise));
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ready && have_prev) |-> (res_src != last_src));
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_ready |=> !res_ready);
    a_r4_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_count) |-> res_ready);
    a_r5_ovf_means_max: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ready && res_ovf) |-> (res_count == CNT_MAX));
    a_r5_a_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a == CNT_MAX) |=> (cnt_a == CNT_MAX || cnt_a == '0));
    a_r6_a_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (cnt_a == '0));
    a_r6_b_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> (cnt_b == '0));
    a_r7_partial_from_b: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ready && res_partial) |-> res_src);

endmodule

bind pps_pingpong_counter pps_pingpong_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pps_rise    (pps_rise),
    .gate        (gate),
    .cnt_a       (cnt_q[0]),
    .cnt_b       (cnt_q[1]),
    .res_count   (res_count),
    .res_src     (res_src),
    .res_ovf     (res_ovf),
    .res_partial (res_partial),
    .res_ready   (res_ready)
);

// File: tb/pps_pingpong_counter_tb.sv
// Bench: drives PPS pulses with random periods and high times plus
// directed corners, and checks each strobed result against a list of
// expected values built from the drive schedule.
module pps_pingpong_counter_tb;
    localparam int unsigned CNT_W   = 10;
    localparam int          MAXV    = (1 << CNT_W) - 1;
    localparam int          NDIR    = 7;
    localparam int          NRND    = 10;
    localparam int          NEXP    = 1 + NDIR + NRND;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pps_in = 1'b0;
    logic [CNT_W-1:0] res_count;
    logic             res_src;
    logic             res_ovf;
    logic             res_partial;
    logic             res_ready;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    bit done   = 1'b0;
    int exp_cnt [NEXP];
    int exp_ovf [NEXP];

    always #4 clk = ~clk;

    pps_pingpong_counter #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pps_in      (pps_in),
        .res_count   (res_count),
        .res_src     (res_src),
        .res_ovf     (res_ovf),
        .res_partial (res_partial),
        .res_ready   (res_ready)
    );

    function automatic int f_count(input int period);
        return (period > MAXV) ? MAXV : period;
    endfunction

    function automatic int f_ovf(input int period);
        return (period > MAXV) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One PPS period: a rising edge, high for hi cycles, then low.
    task automatic pulse(input int period, input int hi);
        pps_in = 1'b1;
        repeat (hi) @(negedge clk);
        pps_in = 1'b0;
        repeat (period - hi) @(negedge clk);
    endtask

    // Result monitor: compare each strobe with the expected list.
    initial begin
        bit prev_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev_ready) check("R4 strobe one cycle", res_ready, 0);
            if (rst_n && res_ready && seen < NEXP) begin
                // R3: first result from B (1), then alternating A (0), B (1)
                check("R3 source", res_src, (seen % 2 == 0) ? 1 : 0);
                check("R7 partial", res_partial, (seen == 0) ? 1 : 0);
                if (seen > 0) begin
                    // R2 count, R5 saturation, R6 cleared windows, R9 high time
                    check("R2/R5/R9 count", res_count, exp_cnt[seen]);
                    check("R5/R6 overflow", res_ovf, exp_ovf[seen]);
                end
                seen++;
            end else if (rst_n && res_ready) begin
                check("R4 extra strobe", 1, 0);
            end
            prev_ready = res_ready;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dir_p [NDIR] = '{6, 7, 1100, 50, 40, 1023, 1024};
        int dir_h [NDIR] = '{5, 1, 3, 49, 20, 1, 1000};
        int k;
        void'($urandom(32'd2024));
        exp_cnt[0] = 0;
        exp_ovf[0] = 0;
        repeat (3) @(negedge clk);
        // R8: reset state while reset is held
        check("R8 ready", res_ready, 0);
        check("R8 count", res_count, 0);
        check("R8 src", res_src, 0);
        check("R8 ovf", res_ovf, 0);
        check("R8 partial", res_partial, 0);
        // R1: hold pps high during reset; no edge may be seen afterwards
        pps_in = 1'b1;
        @(negedge clk);
        pps_in = 1'b0;
        rst_n = 1'b1;
        repeat (37) @(negedge clk);
        k = 1;
        for (int i = 0; i < NDIR; i++) begin
            exp_cnt[k] = f_count(dir_p[i]);
            exp_ovf[k] = f_ovf(dir_p[i]);
            k++;
            pulse(dir_p[i], dir_h[i]);
        end
        for (int i = 0; i < NRND; i++) begin
            int p;
            int h;
            p = 6 + int'($urandom_range(0, 400));
            h = 1 + int'($urandom_range(0, p - 2));
            exp_cnt[k] = f_count(p);
            exp_ovf[k] = f_ovf(p);
            k++;
            pulse(p, h);
        end
        // Closing edge ends the last window.
        pulse(20, 3);
        repeat (10) @(negedge clk);
        check("R3/R4 result total", seen, NEXP);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule